// File: doc/BRIEF.md
# Write-Only Control Register Port over I2C

This block is a receive-only I2C target that loads a bank of four 8-bit control registers for a video processing datapath. A transfer opens with the target's 7-bit address and a write direction bit. The next byte selects a starting register, and every data byte after that is stored and moves the register pointer up by one. One transfer can therefore fill several registers in a row. Each accepted byte is acknowledged by pulling SDA low during the ninth clock. A byte the block rejects is not acknowledged, and the block then stays silent until the next start condition.

SCL and SDA are asynchronous to the system clock and pass through a two-stage synchronizer before any edge is used. Register 0 carries a 2-bit operating mode in bits 7:6, with the codes normal, multi-picture, still-in-picture and picture-in-still. A write to those bits lands in a shadow copy. The copy reaches the mode output only in a clock where the vertical-sync input and the data-request input are both high. All other fields apply as soon as the write completes. A host therefore programs the new mode ahead of time, and the switch happens inside vertical blanking.

Register fields: register 0 holds mode[7:6], narrow frame[5], split screen[3], VCR[2], noise reduction enable[1] and 8-bit input width[0]. Register 1 holds frame grey level[7:5] and lower noise threshold[4:0]. Register 2 holds the upper noise threshold[4:0]. Register 3 holds forced-class enable[7], class[6:5], forced-coefficient enable[4] and coefficient code[3:0].

Top module: `ctl_reg_i2c_slave`

## Requirements
- R1: After reset the register views read cfg0 = 0x00, cfg1 = 0x04, cfg2 = 0x10, cfg3 = 0x00, and SDA is not driven.
- R2: A first byte of 0x2A after a start is acknowledged. This is address 0010101 in bits 7:1 with bit 0 = 0 for a write. The acknowledge is SDA held low during the ninth SCL high phase.
- R3: A first byte whose address differs from 0010101, or whose bit 0 is 1 (read), is not acknowledged. Every later byte up to the next start or stop is neither acknowledged nor stored.
- R4: A second byte of 0x00 to 0x03 is acknowledged and selects the first register written. A larger value is not acknowledged, and the rest of the transfer is ignored.
- R5: Each data byte sent to register 0 to 3 is acknowledged and stored. The pointer then advances by one, so consecutive bytes fill consecutive registers.
- R6: A data byte that arrives when the pointer has passed register 3 is not acknowledged. No register changes, and later bytes of that transfer are ignored.
- R7: Register 2 bits 7:5 and register 0 bit 4 always read zero, whatever value is written to them.
- R8: Bits 7:6 written to register 0 appear on cfg0_o[7:6] only after a clock in which vsync_i and dreq_i are both high. Bits 5:0 appear as soon as the write completes.
- R9: The acknowledge drive starts only while SCL is low. It is released after the SCL falling edge that ends the ninth clock, before the next bit is clocked.
- R10: A repeated start in the middle of a transfer, including one that is being ignored, restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line, asynchronous |
| sda_i | input | 1 | I2C data line as seen on the bus, asynchronous |
| vsync_i | input | 1 | Vertical sync, high during vertical blanking, synchronous to clk |
| dreq_i | input | 1 | Data request that permits the mode switch |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| cfg0_o | output | 8 | Register 0 view, with active mode in bits 7:6 |
| cfg1_o | output | 8 | Register 1: grey level and lower threshold |
| cfg2_o | output | 8 | Register 2: upper threshold, bits 7:5 zero |
| cfg3_o | output | 8 | Register 3: forced class and forced coefficient |

## Verification
A vector table writes single bytes with patterns that include all-ones and mixed values to each register, which separates correct field masking from plain storage. Multi-byte bursts that start at different registers show whether the pointer increments, and whether it stops acknowledging after register 3. Wrong addresses, a read-direction address and an out-of-range subaddress are each followed by extra bytes, which tells an ignored transfer apart from one that only misses one acknowledge. The mode field is driven with vsync alone, dreq alone and then both, which shows whether the shadow copy moves only on the joint condition.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;

  localparam int CFG_REGS = 4;
  localparam int CFG_W    = 8;

  typedef enum logic [1:0] {LNK_IDLE, LNK_RX, LNK_ACK, LNK_SKIP} lnk_state_t;
  typedef enum logic [1:0] {PH_ADDR, PH_SUB, PH_DATA} lnk_phase_t;

  // power-up contents per register index
  function automatic logic [7:0] cfg_reset_val(input int idx);
    case (idx)
      1:       return 8'h04;
      2:       return 8'h10;
      default: return 8'h00;
    endcase
  endfunction

  // bits that hold state; the rest read as zero
  function automatic logic [7:0] cfg_keep_mask(input int idx);
    case (idx)
      0:       return 8'hEF;
      2:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/ctl_i2c_sync.sv
module ctl_i2c_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '1;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/ctl_i2c_cond.sv
module ctl_i2c_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p,
  output logic sda_bit
);

  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      start_p <= 1'b0;
      stop_p  <= 1'b0;
      rise_p  <= 1'b0;
      fall_p  <= 1'b0;
      sda_bit <= 1'b1;
    end else begin
      scl_q   <= scl_s;
      sda_q   <= sda_s;
      // SDA edges while SCL stays high mark bus conditions
      start_p <= scl_s & scl_q & sda_q & ~sda_s;
      stop_p  <= scl_s & scl_q & ~sda_q & sda_s;
      rise_p  <= scl_s & ~scl_q;
      fall_p  <= ~scl_s & scl_q;
      sda_bit <= sda_s;
    end
  end

endmodule

// File: rtl/ctl_i2c_link.sv
module ctl_i2c_link
  import ctl_i2c_pkg::*;
#(
  parameter int         DW       = 8,
  parameter int         NREG     = 4,
  parameter int         PW       = 3,
  parameter logic [6:0] DEV_ADDR = 7'b0010101
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic          rise_p,
  input  logic          fall_p,
  input  logic          sda_bit,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx,
  output logic [DW-1:0] wr_data
);

  localparam logic [PW-1:0] LAST_IDX = PW'(NREG - 1);
  localparam logic [DW-1:0] LAST_SUB = DW'(NREG - 1);
  localparam logic [3:0]    BYTE_END = 4'(DW);

  lnk_state_t    state;
  lnk_phase_t    phase;
  logic [DW-1:0] shreg;
  logic [3:0]    bitcnt;
  logic [PW-1:0] ptr;
  logic          accept;

  // decision on the byte just shifted in
  always_comb begin
    case (phase)
      PH_ADDR: accept = (shreg == {DEV_ADDR, 1'b0});
      PH_SUB:  accept = (shreg <= LAST_SUB);
      default: accept = (ptr <= LAST_IDX);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= LNK_IDLE;
      phase   <= PH_ADDR;
      shreg   <= '0;
      bitcnt  <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_p) begin
        state  <= LNK_RX;
        phase  <= PH_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        state  <= LNK_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          LNK_RX: begin
            if (rise_p && bitcnt < BYTE_END) begin
              shreg  <= {shreg[DW-2:0], sda_bit};
              bitcnt <= bitcnt + 4'd1;
            end else if (fall_p && bitcnt == BYTE_END) begin
              if (accept) begin
                sda_oe <= 1'b1;
                state  <= LNK_ACK;
                if (phase == PH_SUB) ptr <= shreg[PW-1:0];
                if (phase == PH_DATA) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= shreg;
                  ptr     <= ptr + 1'b1;
                end
              end else begin
                state <= LNK_SKIP;
              end
            end
          end
          LNK_ACK: begin
            if (fall_p) begin
              sda_oe <= 1'b0;
              state  <= LNK_RX;
              bitcnt <= '0;
              phase  <= (phase == PH_ADDR) ? PH_SUB : PH_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ctl_i2c_regs.sv
module ctl_i2c_regs
  import ctl_i2c_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int DW     = 8,
  parameter int PW     = 3,
  parameter int MODE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             vsync,
  input  logic             dreq,
  output logic [NREG*DW-1:0] cfg_flat
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] RV = DW'(cfg_reset_val(g));
    localparam logic [DW-1:0] KM = DW'(cfg_keep_mask(g));
    logic [DW-1:0] r;

    always_ff @(posedge clk) begin
      if (rst)                                r <= RV;
      else if (wr_en && wr_idx == PW'(g))     r <= wr_data & KM;
    end

    if (g == 0) begin : g_mode
      // mode field: r holds the shadow, act drives the datapath
      logic [MODE_W-1:0] act;
      always_ff @(posedge clk) begin
        if (rst)                act <= RV[DW-1 -: MODE_W];
        else if (vsync && dreq) act <= r[DW-1 -: MODE_W];
      end
      assign cfg_flat[DW-1:0] = {act, r[DW-MODE_W-1:0]};
    end else begin : g_plain
      assign cfg_flat[g*DW +: DW] = r;
    end
  end

endmodule

// File: rtl/ctl_reg_i2c_slave.sv
module ctl_reg_i2c_slave
  import ctl_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'b0010101
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       vsync_i,
  input  logic       dreq_i,
  output logic       sda_oe_o,
  output logic [7:0] cfg0_o,
  output logic [7:0] cfg1_o,
  output logic [7:0] cfg2_o,
  output logic [7:0] cfg3_o
);

  localparam int NREG   = CFG_REGS;
  localparam int DW     = CFG_W;
  localparam int PW     = $clog2(NREG) + 1;
  localparam int MODE_W = 2;

  logic [1:0]         bus_s;
  logic               start_p, stop_p, rise_p, fall_p, sda_bit;
  logic               wr_en;
  logic [PW-1:0]      wr_idx;
  logic [DW-1:0]      wr_data;
  logic [NREG*DW-1:0] cfg_flat;

  ctl_i2c_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (bus_s)
  );

  ctl_i2c_cond u_cond (
    .clk     (clk),
    .rst     (rst),
    .scl_s   (bus_s[1]),
    .sda_s   (bus_s[0]),
    .start_p (start_p),
    .stop_p  (stop_p),
    .rise_p  (rise_p),
    .fall_p  (fall_p),
    .sda_bit (sda_bit)
  );

  ctl_i2c_link #(.DW(DW), .NREG(NREG), .PW(PW), .DEV_ADDR(DEV_ADDR)) u_link (
    .clk     (clk),
    .rst     (rst),
    .start_p (start_p),
    .stop_p  (stop_p),
    .rise_p  (rise_p),
    .fall_p  (fall_p),
    .sda_bit (sda_bit),
    .sda_oe  (sda_oe_o),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data)
  );

  ctl_i2c_regs #(.NREG(NREG), .DW(DW), .PW(PW), .MODE_W(MODE_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .vsync    (vsync_i),
    .dreq     (dreq_i),
    .cfg_flat (cfg_flat)
  );

  assign cfg0_o = cfg_flat[0*DW +: DW];
  assign cfg1_o = cfg_flat[1*DW +: DW];
  assign cfg2_o = cfg_flat[2*DW +: DW];
  assign cfg3_o = cfg_flat[3*DW +: DW];

endmodule

// File: rtl/ctl_reg_i2c_slave_chk.sv
module ctl_reg_i2c_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       vsync_i,
  input logic       dreq_i,
  input logic       sda_oe_o,
  input logic [7:0] cfg0_o,
  input logic [7:0] cfg1_o,
  input logic [7:0] cfg3_o
);

  // R9
  ack_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_i);

  // R8
  mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(vsync_i && dreq_i) |=> $stable(cfg0_o[7:6]));

  // R5
  cfg1_acked_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg1_o) |-> sda_oe_o);

  // R6
  cfg3_acked_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg3_o) |-> sda_oe_o);

endmodule

bind ctl_reg_i2c_slave ctl_reg_i2c_slave_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_i    (scl_i),
  .vsync_i  (vsync_i),
  .dreq_i   (dreq_i),
  .sda_oe_o (sda_oe_o),
  .cfg0_o   (cfg0_o),
  .cfg1_o   (cfg1_o),
  .cfg3_o   (cfg3_o)
);

// File: tb/test_ctl_reg_i2c_slave.sv
module test_ctl_reg_i2c_slave;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_drv = 1'b1;
  logic       vsync = 1'b0;
  logic       dreq = 1'b0;
  logic       sda_oe;
  logic       sda_line;
  logic [7:0] c0, c1, c2, c3;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  assign sda_line = sda_drv & ~sda_oe;

  ctl_reg_i2c_slave i_ctl_reg_i2c_slave (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .vsync_i  (vsync),
    .dreq_i   (dreq),
    .sda_oe_o (sda_oe),
    .cfg0_o   (c0),
    .cfg1_o   (c1),
    .cfg2_o   (c2),
    .cfg3_o   (c3)
  );

  // {first byte, subaddress, data, expected register view}
  localparam logic [31:0] VEC [6] = '{
    32'h2A01A7A7, 32'h2A02FF1F, 32'h2A035C5C,
    32'h2A003F2F, 32'h2A010000, 32'h2A020B0B
  };

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] view(input logic [7:0] s);
    case (s[1:0])
      2'd0:    return c0;
      2'd1:    return c1;
      2'd2:    return c2;
      default: return c3;
    endcase
  endfunction

  task automatic bus_start;
    sda_drv = 1'b1; idle(Q);
    scl = 1'b1;     idle(Q);
    sda_drv = 1'b0; idle(Q);
    scl = 1'b0;     idle(Q);
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; idle(Q);
    scl = 1'b1;     idle(Q);
    sda_drv = 1'b1; idle(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; idle(Q);
      scl = 1'b1;     idle(Q);
      scl = 1'b0;     idle(2);
    end
    sda_drv = 1'b1; idle(Q);
    scl = 1'b1;     idle(Q/2);
    ack = ~sda_line;
    idle(Q/2);
    scl = 1'b0;     idle(Q);
    // R9: drive released before the next bit
    chk8("R9 ack release", {7'b0, sda_oe}, 8'h00);
  endtask

  task automatic expect_ack(input string tag, input logic [7:0] b, input logic exp);
    logic a;
    send_byte(b, a);
    chk8(tag, {7'b0, a}, {7'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(5);
    // R1 reset values
    chk8("R1 cfg0", c0, 8'h00);
    chk8("R1 cfg1", c1, 8'h04);
    chk8("R1 cfg2", c2, 8'h10);
    chk8("R1 cfg3", c3, 8'h00);
    chk8("R1 sda", {7'b0, sda_oe}, 8'h00);

    // table of single-byte writes: R2 R4 R5 R7
    for (int v = 0; v < 6; v++) begin
      bus_start;
      expect_ack("R2 address ack", VEC[v][31:24], 1'b1);
      expect_ack("R4 subaddress ack", VEC[v][23:16], 1'b1);
      expect_ack("R5 data ack", VEC[v][15:8], 1'b1);
      bus_stop;
      chk8("R5 R7 register view", view(VEC[v][23:16]), VEC[v][7:0]);
    end

    // R8 mode shadowing
    bus_start;
    expect_ack("R2 address ack", 8'h2A, 1'b1);
    expect_ack("R4 subaddress ack", 8'h00, 1'b1);
    expect_ack("R5 data ack", 8'hC6, 1'b1);
    bus_stop;
    chk8("R8 low bits now, mode held", c0, 8'h06);
    vsync = 1'b1; idle(20);
    chk8("R8 vsync without dreq", c0, 8'h06);
    vsync = 1'b0; dreq = 1'b1; idle(20);
    chk8("R8 dreq without vsync", c0, 8'h06);
    vsync = 1'b1; idle(1);
    vsync = 1'b0; dreq = 1'b0; idle(2);
    chk8("R8 mode applied", c0, 8'hC6);

    // R5 burst with auto increment
    bus_start;
    expect_ack("R2 address ack", 8'h2A, 1'b1);
    expect_ack("R4 subaddress ack", 8'h01, 1'b1);
    expect_ack("R5 burst byte 1", 8'h11, 1'b1);
    expect_ack("R5 burst byte 2", 8'h22, 1'b1);
    expect_ack("R5 burst byte 3", 8'h33, 1'b1);
    bus_stop;
    chk8("R5 burst cfg1", c1, 8'h11);
    chk8("R5 R7 burst cfg2", c2, 8'h02);
    chk8("R5 burst cfg3", c3, 8'h33);

    // R6 running past the last register
    bus_start;
    expect_ack("R2 address ack", 8'h2A, 1'b1);
    expect_ack("R4 subaddress ack", 8'h02, 1'b1);
    expect_ack("R6 byte to reg2", 8'h44, 1'b1);
    expect_ack("R6 byte to reg3", 8'h55, 1'b1);
    expect_ack("R6 byte past end", 8'h66, 1'b0);
    expect_ack("R6 byte after nack", 8'h77, 1'b0);
    bus_stop;
    chk8("R6 cfg2", c2, 8'h04);
    chk8("R6 cfg3", c3, 8'h55);
    chk8("R6 cfg0 untouched", c0, 8'hC6);
    chk8("R6 cfg1 untouched", c1, 8'h11);

    // R4 out-of-range subaddress
    bus_start;
    expect_ack("R2 address ack", 8'h2A, 1'b1);
    expect_ack("R4 bad subaddress", 8'h05, 1'b0);
    expect_ack("R4 byte after bad sub", 8'h99, 1'b0);
    bus_stop;
    chk8("R4 cfg1 untouched", c1, 8'h11);
    chk8("R4 cfg2 untouched", c2, 8'h04);

    // R3 wrong address, then R10 repeated start
    bus_start;
    expect_ack("R3 wrong address", 8'h2C, 1'b0);
    expect_ack("R3 ignored sub", 8'h01, 1'b0);
    expect_ack("R3 ignored data", 8'hAA, 1'b0);
    chk8("R3 cfg1 untouched", c1, 8'h11);
    bus_start;
    expect_ack("R10 address after restart", 8'h2A, 1'b1);
    expect_ack("R10 subaddress", 8'h01, 1'b1);
    expect_ack("R10 data", 8'h5A, 1'b1);
    bus_stop;
    chk8("R10 cfg1 written", c1, 8'h5A);

    // R3 read direction
    bus_start;
    expect_ack("R3 read bit", 8'h2B, 1'b0);
    expect_ack("R3 ignored sub", 8'h03, 1'b0);
    expect_ack("R3 ignored data", 8'h00, 1'b0);
    bus_stop;
    chk8("R3 cfg3 untouched", c3, 8'h55);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule